// File: doc/BRIEF.md
# SPI Host Command Transactor

This block is the host side of a command link to a slow SPI peripheral. A user request carries a command byte, a write-payload length with the payload bytes, and a count of response bytes to collect. On an accepted request the block asserts chip select, waits out a setup guard, and clocks a whole frame full duplex in SPI mode 0. Each byte goes out MSB first. Between bytes, after the last clock and after chip select is released, it holds further guard delays. Every delay is a parameter counted in system-clock cycles, so one build can meet microsecond-scale minimums at a real clock rate, and a bench can use short values.

A frame always starts with the command byte, followed by the payload bytes. When a response is wanted, filler bytes follow: one extra filler, plus one filler per requested byte. Bytes the peripheral shifts back during the command, the payload and the first filler are thrown away. The bytes returned from frame position `wr_len + 2` onward go, in order, into a result buffer. The host reads that buffer through a select port together with a valid count. `busy_o` covers the whole transaction. `done_o` pulses once when the final idle guard has elapsed.

Top module: `spi_cmd_xactor`

## Requirements
- R1: After reset and whenever not busy, `nss_o` is 1, `sck_o` is 0, `busy_o` and `done_o` are 0; after reset `rd_count_o` is 0.
- R2: SPI mode 0: SCK idles low, `mosi_o` changes only while SCK is low and is stable for the whole high phase, bytes go MSB first, `miso_i` is sampled at each SCK rising edge MSB first; SCK is never high while `nss_o` is high.
- R3: A frame is: byte 0 = `cmd_i`; bytes 1..W = payload byte k taken from `wr_data_i[8k+7:8k]` (k = 0..W-1); when R > 0, R+1 further bytes equal to FILL_BYTE (default 0x00). The total is 1 + W + (R > 0 ? R + 1 : 0) bytes, where W and R are the clamped lengths.
- R4: Within a byte, each SCK high phase and each SCK low phase between bits lasts exactly SCK_HALF_CYC cycles.
- R5: The first SCK rising edge comes exactly SETUP_CYC cycles after `nss_o` falls.
- R6: From the last falling SCK edge of one byte to the first rising edge of the next byte is exactly GAP_CYC cycles, with SCK low.
- R7: `nss_o` rises exactly HOLD_CYC cycles after the last falling SCK edge of the frame.
- R8: `done_o` is high for exactly one cycle, IDLE_CYC cycles after `nss_o` rises, and in that cycle `busy_o` is already 0.
- R9: The byte received at frame position `wr_len + 2 + j` is stored at buffer entry j (read through `rd_sel_i`/`rd_byte_o`). Earlier received bytes are discarded. At `done_o`, `rd_count_o` equals R. An accepted request clears the count.
- R10: A `start_i` pulse while `busy_o` is 1 is ignored: the running frame and its results are unchanged. `busy_o` is 1 in the cycle after an accepted start.
- R11: A write length above WR_MAX is treated as WR_MAX, and a read length above RD_MAX is treated as RD_MAX.
- R12: Request inputs are captured when the start is accepted; changing them during the transaction does not affect the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse, accepted only when idle |
| cmd_i | input | 8 | Command byte |
| wr_len_i | input | $clog2(WR_MAX+1) | Payload byte count |
| wr_data_i | input | WR_MAX*8 | Payload bytes, byte k at bits [8k+7:8k] |
| rd_len_i | input | $clog2(RD_MAX+1) | Number of response bytes to collect |
| rd_sel_i | input | $clog2(RD_MAX+1) | Result buffer entry select |
| rd_byte_o | output | 8 | Selected result byte |
| rd_count_o | output | $clog2(RD_MAX+1) | Number of valid result bytes |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| nss_o | output | 1 | Chip select, active low |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the peripheral |
| miso_i | input | 1 | Serial data from the peripheral |

## Verification
A wrong phase counter or state shows at the pins within one guard interval. The cycle distance between an SCK or chip-select edge and its neighbour moves off the exact parameter value, and SCK or MOSI toggles in a phase where it must hold. A wrong byte index or a mistaken capture decision does not show until the frame ends, as a wrong byte count on MOSI, a wrong payload or filler byte, or a result buffer that is shifted or short. The bench therefore times every edge in cycles and compares the whole frame and the whole buffer after each `done_o`.

// File: rtl/spix_pkg.sv
package spix_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_GAP,
        ST_HOLD,
        ST_REST
    } xfer_state_e;

    typedef struct packed {
        logic nss;
        logic sck;
    } spi_ctl_t;

    function automatic int clamp_len(int req, int lim);
        return (req > lim) ? lim : req;
    endfunction

    function automatic int frame_bytes(int wl, int rl);
        return 1 + wl + ((rl > 0) ? rl + 1 : 0);
    endfunction

    function automatic int max_of4(int a, int b, int c, int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/spix_frame_src.sv
module spix_frame_src
    import spix_pkg::*;
#(
    parameter int          WR_MAX = 12,
    parameter int          RD_MAX = 20,
    parameter int          WLW    = 4,
    parameter int          RLW    = 5,
    parameter int          FW     = 6,
    parameter logic [7:0]  FILL   = 8'h00
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load_i,
    input  logic [BYTE_W-1:0]         cmd_i,
    input  logic [WLW-1:0]            wr_len_i,
    input  logic [WR_MAX*BYTE_W-1:0]  wr_data_i,
    input  logic [RLW-1:0]            rd_len_i,
    input  logic [FW-1:0]             idx_i,
    output logic [BYTE_W-1:0]         byte_o,
    output logic [FW-1:0]             last_idx_o,
    output logic [FW-1:0]             cap_base_o,
    output logic                      cap_en_o
);

    logic [BYTE_W-1:0]        cmd_q;
    logic [WR_MAX*BYTE_W-1:0] data_q;
    logic [WLW-1:0]           wl_q;
    logic [RLW-1:0]           rl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            data_q <= '0;
            wl_q   <= '0;
            rl_q   <= '0;
        end else if (load_i) begin
            cmd_q  <= cmd_i;
            data_q <= wr_data_i;
            wl_q   <= WLW'(clamp_len(int'(wr_len_i), WR_MAX));
            rl_q   <= RLW'(clamp_len(int'(rd_len_i), RD_MAX));
        end
    end

    always_comb begin
        byte_o = FILL;
        if (idx_i == '0) begin
            byte_o = cmd_q;
        end
        for (int j = 0; j < WR_MAX; j++) begin
            if (int'(idx_i) == j + 1 && j < int'(wl_q)) begin
                byte_o = data_q[j*BYTE_W +: BYTE_W];
            end
        end
    end

    assign last_idx_o = FW'(frame_bytes(int'(wl_q), int'(rl_q)) - 1);
    assign cap_base_o = FW'(int'(wl_q) + 2);
    assign cap_en_o   = (rl_q != '0);

endmodule

// File: rtl/spix_engine.sv
module spix_engine
    import spix_pkg::*;
#(
    parameter int HALF_CYC  = 200,
    parameter int SETUP_CYC = 3250,
    parameter int GAP_CYC   = 2000,
    parameter int HOLD_CYC  = 5000,
    parameter int IDLE_CYC  = 2500,
    parameter int FW        = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [BYTE_W-1:0] first_byte_i,
    input  logic [BYTE_W-1:0] next_byte_i,
    input  logic [FW-1:0]     last_idx_i,
    input  logic              miso_i,
    output spi_ctl_t          ctl_o,
    output logic              mosi_o,
    output logic [FW-1:0]     byte_idx_o,
    output logic              rx_stb_o,
    output logic [FW-1:0]     rx_idx_o,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int MAXC = max_of4(max_of4(HALF_CYC, SETUP_CYC, GAP_CYC, HOLD_CYC), IDLE_CYC, 1, 1);
    localparam int CW   = $clog2(MAXC + 1);

    xfer_state_e       st;
    spi_ctl_t          ctl;
    logic [CW-1:0]     cnt;
    logic [2:0]        bit_idx;
    logic [FW-1:0]     byte_idx;
    logic [BYTE_W-1:0] tx_sh;
    logic [BYTE_W-1:0] rx_sh;
    logic              cnt_zero;

    assign cnt_zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            ctl      <= '{nss: 1'b1, sck: 1'b0};
            cnt      <= '0;
            bit_idx  <= '0;
            byte_idx <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            rx_stb_o <= 1'b0;
            rx_idx_o <= '0;
            done_o   <= 1'b0;
        end else begin
            rx_stb_o <= 1'b0;
            done_o   <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start_i) begin
                        ctl.nss  <= 1'b0;
                        tx_sh    <= first_byte_i;
                        byte_idx <= '0;
                        bit_idx  <= 3'd7;
                        cnt      <= CW'(SETUP_CYC - 1);
                        st       <= ST_SETUP;
                    end
                end
                ST_SETUP, ST_LOW, ST_GAP: begin
                    if (cnt_zero) begin
                        ctl.sck <= 1'b1;
                        rx_sh   <= {rx_sh[BYTE_W-2:0], miso_i};
                        cnt     <= CW'(HALF_CYC - 1);
                        st      <= ST_HIGH;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (cnt_zero) begin
                        ctl.sck <= 1'b0;
                        if (bit_idx == '0) begin
                            rx_stb_o <= 1'b1;
                            rx_idx_o <= byte_idx;
                            if (byte_idx == last_idx_i) begin
                                cnt <= CW'(HOLD_CYC - 1);
                                st  <= ST_HOLD;
                            end else begin
                                byte_idx <= byte_idx + 1'b1;
                                tx_sh    <= next_byte_i;
                                bit_idx  <= 3'd7;
                                cnt      <= CW'(GAP_CYC - 1);
                                st       <= ST_GAP;
                            end
                        end else begin
                            bit_idx <= bit_idx - 1'b1;
                            tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
                            cnt     <= CW'(HALF_CYC - 1);
                            st      <= ST_LOW;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (cnt_zero) begin
                        ctl.nss <= 1'b1;
                        cnt     <= CW'(IDLE_CYC - 1);
                        st      <= ST_REST;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_REST: begin
                    if (cnt_zero) begin
                        done_o <= 1'b1;
                        st     <= ST_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign ctl_o      = ctl;
    assign mosi_o     = tx_sh[BYTE_W-1];
    assign byte_idx_o = byte_idx;
    assign rx_byte_o  = rx_sh;
    assign busy_o     = (st != ST_IDLE);

endmodule

// File: rtl/spix_rxbuf.sv
module spix_rxbuf
    import spix_pkg::*;
#(
    parameter int RD_MAX = 20,
    parameter int RLW    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              wr_en_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic [RLW-1:0]    rd_sel_i,
    output logic [BYTE_W-1:0] rd_byte_o,
    output logic [RLW-1:0]    count_o
);

    logic [BYTE_W-1:0] mem [RD_MAX];
    logic [RLW-1:0]    count_q;
    logic              room;

    assign room = (count_q < RLW'(RD_MAX));

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            count_q <= '0;
        end else if (wr_en_i && room) begin
            count_q <= count_q + 1'b1;
        end
    end

    for (genvar g = 0; g < RD_MAX; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!clear_i && wr_en_i && count_q == RLW'(g)) begin
                mem[g] <= wr_data_i;
            end
        end
    end

    always_comb begin
        rd_byte_o = '0;
        for (int j = 0; j < RD_MAX; j++) begin
            if (rd_sel_i == RLW'(j)) begin
                rd_byte_o = mem[j];
            end
        end
    end

    assign count_o = count_q;

endmodule

// File: rtl/spi_cmd_xactor.sv
module spi_cmd_xactor
    import spix_pkg::*;
#(
    parameter int          WR_MAX       = 12,
    parameter int          RD_MAX       = 20,
    parameter int          SCK_HALF_CYC = 200,
    parameter int          SETUP_CYC    = 3250,
    parameter int          GAP_CYC      = 2000,
    parameter int          HOLD_CYC     = 5000,
    parameter int          IDLE_CYC     = 2500,
    parameter logic [7:0]  FILL_BYTE    = 8'h00,
    localparam int         WLW          = $clog2(WR_MAX + 1),
    localparam int         RLW          = $clog2(RD_MAX + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_i,
    input  logic [7:0]             cmd_i,
    input  logic [WLW-1:0]         wr_len_i,
    input  logic [WR_MAX*8-1:0]    wr_data_i,
    input  logic [RLW-1:0]         rd_len_i,
    input  logic [RLW-1:0]         rd_sel_i,
    output logic [7:0]             rd_byte_o,
    output logic [RLW-1:0]         rd_count_o,
    output logic                   busy_o,
    output logic                   done_o,
    output logic                   nss_o,
    output logic                   sck_o,
    output logic                   mosi_o,
    input  logic                   miso_i
);

    localparam int FW = $clog2(WR_MAX + RD_MAX + 3);

    logic              accept;
    logic [FW-1:0]     byte_idx;
    logic [FW-1:0]     next_idx;
    logic [BYTE_W-1:0] next_byte;
    logic [FW-1:0]     last_idx;
    logic [FW-1:0]     cap_base;
    logic              cap_en;
    logic              rx_stb;
    logic [FW-1:0]     rx_idx;
    logic [BYTE_W-1:0] rx_byte;
    logic              capture;
    spi_ctl_t          ctl;

    assign accept   = start_i && !busy_o;
    assign next_idx = byte_idx + 1'b1;
    assign capture  = rx_stb && cap_en && (rx_idx >= cap_base);

    spix_frame_src #(
        .WR_MAX (WR_MAX),
        .RD_MAX (RD_MAX),
        .WLW    (WLW),
        .RLW    (RLW),
        .FW     (FW),
        .FILL   (FILL_BYTE)
    ) src_i (
        .clk        (clk),
        .rst        (rst),
        .load_i     (accept),
        .cmd_i      (cmd_i),
        .wr_len_i   (wr_len_i),
        .wr_data_i  (wr_data_i),
        .rd_len_i   (rd_len_i),
        .idx_i      (next_idx),
        .byte_o     (next_byte),
        .last_idx_o (last_idx),
        .cap_base_o (cap_base),
        .cap_en_o   (cap_en)
    );

    spix_engine #(
        .HALF_CYC  (SCK_HALF_CYC),
        .SETUP_CYC (SETUP_CYC),
        .GAP_CYC   (GAP_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .IDLE_CYC  (IDLE_CYC),
        .FW        (FW)
    ) eng_i (
        .clk          (clk),
        .rst          (rst),
        .start_i      (accept),
        .first_byte_i (cmd_i),
        .next_byte_i  (next_byte),
        .last_idx_i   (last_idx),
        .miso_i       (miso_i),
        .ctl_o        (ctl),
        .mosi_o       (mosi_o),
        .byte_idx_o   (byte_idx),
        .rx_stb_o     (rx_stb),
        .rx_idx_o     (rx_idx),
        .rx_byte_o    (rx_byte),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    spix_rxbuf #(
        .RD_MAX (RD_MAX),
        .RLW    (RLW)
    ) buf_i (
        .clk       (clk),
        .rst       (rst),
        .clear_i   (accept),
        .wr_en_i   (capture),
        .wr_data_i (rx_byte),
        .rd_sel_i  (rd_sel_i),
        .rd_byte_o (rd_byte_o),
        .count_o   (rd_count_o)
    );

    assign nss_o = ctl.nss;
    assign sck_o = ctl.sck;

endmodule

// File: rtl/spix_checker.sv
module spix_checker #(
    parameter int RD_MAX    = 20,
    parameter int SETUP_CYC = 3250,
    parameter int RLW       = 5
) (
    input logic           clk,
    input logic           rst,
    input logic           start_i,
    input logic           busy_o,
    input logic           done_o,
    input logic           nss_o,
    input logic           sck_o,
    input logic           mosi_o,
    input logic [RLW-1:0] rd_count_o
);

    logic        nss_prev;
    logic        armed;
    logic [31:0] since;

    always_ff @(posedge clk) begin
        if (rst) begin
            nss_prev <= 1'b1;
            armed    <= 1'b0;
            since    <= '0;
        end else begin
            nss_prev <= nss_o;
            if (nss_prev && !nss_o) begin
                armed <= 1'b1;
                since <= 32'd1;
            end else if (armed) begin
                since <= since + 32'd1;
                if (sck_o) armed <= 1'b0;
            end
        end
    end

    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (nss_o && !sck_o)); // R1

    AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (sck_o && $past(sck_o)) |-> $stable(mosi_o)); // R2

    AST_SCK_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
        sck_o |-> !nss_o); // R2

    AST_SETUP_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (armed && $rose(sck_o)) |-> (since == 32'(SETUP_CYC))); // R5

    AST_RELEASE_SCK_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(nss_o) |-> (!sck_o && !$past(sck_o))); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R8

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && nss_o)); // R8

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> (busy_o && !nss_o)); // R10

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        rd_count_o <= RLW'(RD_MAX)); // R9

endmodule

bind spi_cmd_xactor spix_checker #(
    .RD_MAX    (RD_MAX),
    .SETUP_CYC (SETUP_CYC),
    .RLW       (RLW)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .nss_o      (nss_o),
    .sck_o      (sck_o),
    .mosi_o     (mosi_o),
    .rd_count_o (rd_count_o)
);

// File: tb/spi_cmd_xactor_tb_top.sv
`timescale 1ns/1ps
module spi_cmd_xactor_tb_top;

    localparam int WMAX  = 12;
    localparam int RMAX  = 20;
    localparam int HALF  = 3;
    localparam int SETUP = 13;
    localparam int GAP   = 8;
    localparam int HOLD  = 20;
    localparam int IDLE  = 10;
    localparam logic [7:0] FILL = 8'h00;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start_i = 1'b0;
    logic [7:0]      cmd_i = '0;
    logic [3:0]      wr_len_i = '0;
    logic [WMAX*8-1:0] wr_data_i = '0;
    logic [4:0]      rd_len_i = '0;
    logic [4:0]      rd_sel_i = '0;
    logic [7:0]      rd_byte_o;
    logic [4:0]      rd_count_o;
    logic            busy_o, done_o, nss_o, sck_o, mosi_o;
    logic            miso_i = 1'b0;

    always #10 clk = ~clk;

    spi_cmd_xactor #(
        .WR_MAX(WMAX), .RD_MAX(RMAX), .SCK_HALF_CYC(HALF), .SETUP_CYC(SETUP),
        .GAP_CYC(GAP), .HOLD_CYC(HOLD), .IDLE_CYC(IDLE), .FILL_BYTE(FILL)
    ) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .cmd_i(cmd_i), .wr_len_i(wr_len_i),
        .wr_data_i(wr_data_i), .rd_len_i(rd_len_i), .rd_sel_i(rd_sel_i),
        .rd_byte_o(rd_byte_o), .rd_count_o(rd_count_o), .busy_o(busy_o), .done_o(done_o),
        .nss_o(nss_o), .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // peripheral model and edge monitor
    logic [7:0] resp [64];
    logic [7:0] seen [64];
    int   nbytes = 0;
    int   bitcnt = 0;
    logic [7:0] cur = '0;
    bit   first_rise = 0;
    bit   done_seen  = 0;
    bit   mon_on     = 0;
    int   t_nfall = 0, t_rise = 0, t_fall = 0, t_nrise = 0;
    logic p_nss = 1'b1, p_sck = 1'b0, mosi_at_rise = 1'b0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (mon_on) begin
            if (p_nss && !nss_o) begin
                t_nfall = cyc; first_rise = 1; bitcnt = 0; nbytes = 0;
            end
            if (!p_sck && sck_o) begin
                if (first_rise)
                    chk(cyc - t_nfall == SETUP, "R5 setup", cyc - t_nfall, SETUP);
                else if (bitcnt % 8 == 0)
                    chk(cyc - t_fall == GAP, "R6 gap", cyc - t_fall, GAP);
                else
                    chk(cyc - t_fall == HALF, "R4 low", cyc - t_fall, HALF);
                first_rise = 0;
                t_rise = cyc;
                mosi_at_rise = mosi_o;
                cur = {cur[6:0], mosi_o};
            end
            if (p_sck && sck_o)
                chk(mosi_o == mosi_at_rise, "R2 mosi held", mosi_o, mosi_at_rise);
            if (p_sck && !sck_o) begin
                chk(cyc - t_rise == HALF, "R4 high", cyc - t_rise, HALF);
                t_fall = cyc;
                bitcnt++;
                if (bitcnt % 8 == 0) begin
                    if (nbytes < 64) seen[nbytes] = cur;
                    nbytes++;
                end
            end
            if (!p_nss && nss_o) begin
                chk(cyc - t_fall == HOLD, "R7 hold", cyc - t_fall, HOLD);
                t_nrise = cyc;
            end
            if (done_o) begin
                chk(cyc - t_nrise == IDLE, "R8 idle", cyc - t_nrise, IDLE);
                chk(busy_o == 1'b0, "R8 busy low at done", busy_o, 0);
                done_seen = 1;
            end
            p_nss = nss_o;
            p_sck = sck_o;
            if (!nss_o && (bitcnt / 8) < 64)
                miso_i = resp[bitcnt / 8][7 - (bitcnt % 8)];
            else
                miso_i = 1'b0;
        end
    end

    function automatic int clampv(int v, int lim);
        return (v > lim) ? lim : v;
    endfunction

    function automatic logic [7:0] exp_byte(int i, logic [7:0] c, logic [WMAX*8-1:0] wd, int wl);
        if (i == 0) return c;
        if (i <= wl) return wd[(i-1)*8 +: 8];
        return FILL;
    endfunction

    task automatic run_txn(input logic [7:0] c, input int wl, input int rl, input bit poke);
        logic [WMAX*8-1:0] wd;
        int ewl, erl, en, done_wait;
        wd  = {$urandom(), $urandom(), $urandom()};
        ewl = clampv(wl, WMAX);
        erl = clampv(rl, RMAX);
        en  = 1 + ewl + ((erl > 0) ? erl + 1 : 0);
        for (int i = 0; i < 64; i++) resp[i] = 8'($urandom());
        @(negedge clk);
        cmd_i = c; wr_len_i = 4'(wl); rd_len_i = 5'(rl); wr_data_i = wd;
        start_i = 1'b1; done_seen = 0;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R10 busy after accepted start", busy_o, 1);
        // R12: disturb request inputs during the transaction
        cmd_i = ~c; wr_data_i = ~wd; rd_len_i = 5'd0; wr_len_i = 4'd0;
        if (poke) begin
            repeat (7) @(negedge clk);
            cmd_i = 8'hFF; rd_len_i = 5'd3;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        done_wait = 0;
        while (!done_seen && done_wait < 20000) begin
            @(negedge clk);
            done_wait++;
        end
        chk(done_seen, "R8 done seen", done_seen, 1);
        chk(nbytes == en, poke ? "R10 frame length with ignored start" : "R3 frame length", nbytes, en);
        for (int i = 0; i < en && i < 64; i++)
            chk(seen[i] == exp_byte(i, c, wd, ewl), "R3/R12 mosi byte", seen[i], exp_byte(i, c, wd, ewl));
        chk(int'(rd_count_o) == erl, "R9 rd_count", rd_count_o, erl);
        for (int j = 0; j < erl; j++) begin
            rd_sel_i = 5'(j);
            #1;
            chk(rd_byte_o == resp[ewl + 2 + j], "R9 captured byte", rd_byte_o, resp[ewl + 2 + j]);
        end
        if (wl > WMAX || rl > RMAX)
            chk(nbytes == en && int'(rd_count_o) == erl, "R11 clamped lengths", nbytes, en);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        chk(nss_o == 1'b1, "R1 nss idle", nss_o, 1);
        chk(sck_o == 1'b0, "R1 sck idle", sck_o, 0);
        chk(busy_o == 1'b0 && done_o == 1'b0, "R1 busy/done idle", {busy_o, done_o}, 0);
        rst = 1'b0;
        mon_on = 1;
        repeat (2) @(negedge clk);
        chk(rd_count_o == '0, "R1 rd_count after reset", rd_count_o, 0);
        chk(nss_o == 1'b1 && sck_o == 1'b0, "R1 lines after reset", {nss_o, sck_o}, 2);

        // directed corner cases
        run_txn(8'h01, 0, 0, 0);     // single command byte
        run_txn(8'h04, 0, 1, 0);     // one byte read
        run_txn(8'h0A, 0, 3, 0);     // multi-byte read
        run_txn(8'h07, 12, 0, 0);    // full write payload
        run_txn(8'h11, 4, 0, 1);     // write with ignored start
        run_txn(8'h5A, 2, 2, 0);     // write then read
        run_txn(8'h0F, 15, 31, 0);   // both lengths clamped (R11)
        run_txn(8'h13, 0, 20, 1);    // full buffer, ignored start
        // random mix
        for (int k = 0; k < 20; k++)
            run_txn(8'($urandom()), int'($urandom_range(0, 12)),
                    int'($urandom_range(0, 20)), bit'($urandom_range(0, 1)));

        repeat (5) @(negedge clk);
        chk(nss_o == 1'b1 && busy_o == 1'b0, "R1 idle at end", {nss_o, busy_o}, 2);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule